// File: doc/BRIEF.md
# USB Host Controller Status and Interrupt Register

This block holds the status word of a USB host controller together with its run/stop control bit. Hardware event pulses from the transfer engine set individual status flags: descriptor completion, transaction error, resume signalling, and two fatal error classes. Software reads the word through a small word-addressed register port and clears a flag by writing a 1 to its position. Writing 0 to a position leaves that flag as it is.

The two fatal conditions are a descriptor consistency failure and a system bus error. Either one stops the controller by dropping the run/stop bit. One cycle after run/stop falls, for any reason, the block raises the halted flag. A level interrupt output combines the status flags with per-source enable inputs. The two fatal flags are always enabled. The output stays high until software clears every flag that is active and enabled.

The schedule engine drives the event inputs, and the run output gates schedule execution.

Top module: `uhc_status_ctl`

## Requirements
- R1: Synchronous reset leaves the status word at 0x0020 (only halted set), the command word at 0x0000, the run output low and the interrupt output low.
- R2: The status word is laid out as follows: bit 0 completion, bit 1 transaction error, bit 2 resume detect, bit 3 system error, bit 4 process error, bit 5 halted. Bits 15:6 always read 0, and writes to them have no effect. In the command word, only bit 0 (run/stop) is implemented and the other bits read 0.
- R3: Writing 1 to a status bit clears it. Writing 0 leaves the bit unchanged.
- R4: Bit 0 is set by a descriptor completion with interrupt-on-complete requested. It is also set by a short packet while short-packet detection is enabled. A completion without the request does not set it, and neither does a short packet without detection enabled.
- R5: A transaction error sets bit 1. If interrupt-on-complete is also requested in that cycle, bit 0 is set in the same cycle.
- R6: A resume event sets bit 2 only while the global-suspend input is 1. Otherwise it has no effect.
- R7: A descriptor consistency failure sets bit 4 and clears run/stop on the same edge.
- R8: A system bus error sets bit 3 and clears run/stop on the same edge.
- R9: The halted bit sets one cycle after run/stop falls, whether software or hardware cleared run/stop. Writing run/stop back to 1 does not clear the halted bit.
- R10: When a hardware set and a software write-1 clear hit the same bit on the same edge, the bit ends up set.
- R11: The interrupt output is high exactly when at least one of these holds: bit 3 is set, bit 4 is set, or one of bits 0 to 2 is set with its enable input high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Word offset (0 command, 1 status) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| ev_td_done | input | 1 | Descriptor completed |
| ev_td_ioc | input | 1 | Descriptor requested interrupt-on-complete |
| ev_td_err | input | 1 | Transaction ended in error |
| ev_short | input | 1 | Short packet seen |
| ev_short_en | input | 1 | Short-packet detection enabled for that descriptor |
| ev_resume | input | 1 | Resume signalling seen from a device |
| ev_consist_fail | input | 1 | Descriptor consistency check failed |
| ev_sysbus_err | input | 1 | System bus parity error or abort |
| gsusp | input | 1 | Global suspend state |
| ie_done | input | 1 | Interrupt enable for bit 0 |
| ie_err | input | 1 | Interrupt enable for bit 1 |
| ie_resume | input | 1 | Interrupt enable for bit 2 |
| run_out | output | 1 | Run/stop state |
| halted_out | output | 1 | Halted flag |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a hardware set and a software clear hitting the same status bit on the same clock edge. From the ports, this needs a register write strobe and an event pulse held in exactly the same cycle. The bench drives both in a single step and then reads the bit back. A second awkward window is the single cycle between a fatal error and the halted flag. The bench reads the status word right after the fatal edge, and again one edge later, to confirm that the flag appears only after the delay.

// File: rtl/uhc_sts_pkg.sv
package uhc_sts_pkg;

    localparam int DATA_W = 16;
    localparam int NSTS   = 6;

    localparam int B_DONE = 0;
    localparam int B_ERR  = 1;
    localparam int B_RSM  = 2;
    localparam int B_SYS  = 3;
    localparam int B_PROC = 4;
    localparam int B_HALT = 5;

    localparam int CMD_RUN_BIT = 0;
    localparam int NEN         = 3;

    typedef logic [NSTS-1:0] sts_vec_t;

    localparam sts_vec_t STS_RST = sts_vec_t'(1) << B_HALT;

    typedef struct packed {
        logic td_done;
        logic td_ioc;
        logic td_err;
        logic short_pkt;
        logic short_en;
        logic resume;
        logic gsusp;
        logic consist_fail;
        logic sysbus_err;
    } uhc_evt_t;

    function automatic logic [DATA_W-1:0] widen_sts(input sts_vec_t v);
        return {{(DATA_W - NSTS){1'b0}}, v};
    endfunction

    function automatic logic irq_reduce(input sts_vec_t s, input logic [NEN-1:0] en);
        return (|(s[NEN-1:0] & en)) | s[B_SYS] | s[B_PROC];
    endfunction

endpackage

// File: rtl/uhc_evt_decode.sv
module uhc_evt_decode
    import uhc_sts_pkg::*;
(
    input  uhc_evt_t ev,
    output sts_vec_t set_vec
);
    always_comb begin
        set_vec         = '0;
        set_vec[B_DONE] = (ev.td_done & ev.td_ioc)
                        | (ev.td_err & ev.td_ioc)
                        | (ev.short_pkt & ev.short_en);
        set_vec[B_ERR]  = ev.td_err;
        set_vec[B_RSM]  = ev.resume & ev.gsusp;
        set_vec[B_SYS]  = ev.sysbus_err;
        set_vec[B_PROC] = ev.consist_fail;
    end
endmodule

// File: rtl/uhc_run_ctl.sv
module uhc_run_ctl (
    input  logic clk,
    input  logic rst,
    input  logic cmd_we,
    input  logic cmd_run,
    input  logic fatal,
    output logic run,
    output logic halt_set
);
    logic run_q;
    logic run_d1;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            run_d1 <= 1'b0;
        end else begin
            run_d1 <= run_q;
            if (fatal)
                run_q <= 1'b0;
            else if (cmd_we)
                run_q <= cmd_run;
        end
    end

    assign run      = run_q;
    assign halt_set = run_d1 & ~run_q;
endmodule

// File: rtl/uhc_w1c_bank.sv
module uhc_w1c_bank #(
    parameter int N = 6,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)
                bit_q <= RST_VAL[i];
            else if (set_i[i])
                bit_q <= 1'b1;
            else if (clr_i[i])
                bit_q <= 1'b0;
        end
        assign q[i] = bit_q;
    end
endmodule

// File: rtl/uhc_irq_mux.sv
module uhc_irq_mux
    import uhc_sts_pkg::*;
(
    input  sts_vec_t       sts,
    input  logic [NEN-1:0] en,
    output logic           irq
);
    always_comb irq = irq_reduce(sts, en);
endmodule

// File: rtl/uhc_status_ctl.sv
module uhc_status_ctl
    import uhc_sts_pkg::*;
#(
    parameter int ADDR_W  = 2,
    parameter int CMD_OFS = 0,
    parameter int STS_OFS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              ev_td_done,
    input  logic              ev_td_ioc,
    input  logic              ev_td_err,
    input  logic              ev_short,
    input  logic              ev_short_en,
    input  logic              ev_resume,
    input  logic              ev_consist_fail,
    input  logic              ev_sysbus_err,
    input  logic              gsusp,
    input  logic              ie_done,
    input  logic              ie_err,
    input  logic              ie_resume,
    output logic              run_out,
    output logic              halted_out,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(CMD_OFS);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(STS_OFS);

    uhc_evt_t ev;
    sts_vec_t hw_set;
    sts_vec_t set_all;
    sts_vec_t sw_clr;
    sts_vec_t sts_q;
    logic     halt_set;
    logic     run;
    logic     cmd_we;
    logic     sts_we;

    always_comb begin
        ev.td_done      = ev_td_done;
        ev.td_ioc       = ev_td_ioc;
        ev.td_err       = ev_td_err;
        ev.short_pkt    = ev_short;
        ev.short_en     = ev_short_en;
        ev.resume       = ev_resume;
        ev.gsusp        = gsusp;
        ev.consist_fail = ev_consist_fail;
        ev.sysbus_err   = ev_sysbus_err;
    end

    assign cmd_we = reg_wr && (reg_addr == A_CMD);
    assign sts_we = reg_wr && (reg_addr == A_STS);

    uhc_evt_decode u_dec (
        .ev      (ev),
        .set_vec (hw_set)
    );

    uhc_run_ctl u_run (
        .clk      (clk),
        .rst      (rst),
        .cmd_we   (cmd_we),
        .cmd_run  (reg_wdata[CMD_RUN_BIT]),
        .fatal    (ev_consist_fail | ev_sysbus_err),
        .run      (run),
        .halt_set (halt_set)
    );

    always_comb begin
        set_all         = hw_set;
        set_all[B_HALT] = halt_set;
        sw_clr          = sts_we ? reg_wdata[NSTS-1:0] : '0;
    end

    uhc_w1c_bank #(
        .N       (NSTS),
        .RST_VAL (STS_RST)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_all),
        .clr_i (sw_clr),
        .q     (sts_q)
    );

    uhc_irq_mux u_irq (
        .sts (sts_q),
        .en  ({ie_resume, ie_err, ie_done}),
        .irq (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_STS)
            reg_rdata = widen_sts(sts_q);
        else if (reg_addr == A_CMD)
            reg_rdata[CMD_RUN_BIT] = run;
    end

    assign run_out    = run;
    assign halted_out = sts_q[B_HALT];
endmodule

// File: rtl/uhc_status_chk.sv
module uhc_status_chk
    import uhc_sts_pkg::*;
#(
    parameter int ADDR_W  = 2,
    parameter int STS_OFS = 1
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [15:0]       reg_wdata,
    input logic [15:0]       reg_rdata,
    input logic              ev_td_err,
    input logic              ev_resume,
    input logic              ev_consist_fail,
    input logic              ev_sysbus_err,
    input logic              gsusp,
    input logic              run_out,
    input logic              halted_out,
    input logic              irq,
    input sts_vec_t          sts_q
);
    logic sts_sel;
    assign sts_sel = (reg_addr == ADDR_W'(STS_OFS));

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        sts_sel |-> (reg_rdata[15:6] == 10'd0));

    p_w1c_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && sts_sel && reg_wdata[B_ERR] && !ev_td_err) |=> !sts_q[B_ERR]);

    p_zero_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        (sts_q[B_DONE] && !(reg_wr && sts_sel && reg_wdata[B_DONE])) |=> sts_q[B_DONE]);

    p_resume_gated_r6: assert property (@(posedge clk) disable iff (rst)
        (!gsusp && !sts_q[B_RSM]) |=> !sts_q[B_RSM]);

    p_consist_stop_r7: assert property (@(posedge clk) disable iff (rst)
        ev_consist_fail |=> (!run_out && sts_q[B_PROC]));

    p_sysbus_stop_r8: assert property (@(posedge clk) disable iff (rst)
        ev_sysbus_err |=> (!run_out && sts_q[B_SYS]));

    p_halt_follows_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(run_out) |=> halted_out);

    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (halted_out && !(reg_wr && sts_sel && reg_wdata[B_HALT])) |=> halted_out);

    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (ev_td_err && reg_wr && sts_sel && reg_wdata[B_ERR]) |=> sts_q[B_ERR]);

    p_fatal_irq_r11: assert property (@(posedge clk) disable iff (rst)
        (sts_q[B_SYS] || sts_q[B_PROC]) |-> irq);

    p_idle_irq_r11: assert property (@(posedge clk) disable iff (rst)
        (sts_q[4:0] == 5'd0) |-> !irq);
endmodule

bind uhc_status_ctl uhc_status_chk #(
    .ADDR_W  (ADDR_W),
    .STS_OFS (STS_OFS)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .reg_addr        (reg_addr),
    .reg_wr          (reg_wr),
    .reg_wdata       (reg_wdata),
    .reg_rdata       (reg_rdata),
    .ev_td_err       (ev_td_err),
    .ev_resume       (ev_resume),
    .ev_consist_fail (ev_consist_fail),
    .ev_sysbus_err   (ev_sysbus_err),
    .gsusp           (gsusp),
    .run_out         (run_out),
    .halted_out      (halted_out),
    .irq             (irq),
    .sts_q           (sts_q)
);

// File: tb/sim_uhc_status_ctl.sv
module sim_uhc_status_ctl;
    localparam logic [1:0] A_CMD = 2'd0;
    localparam logic [1:0] A_STS = 2'd1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_addr = A_STS;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic ev_td_done = 0, ev_td_ioc = 0, ev_td_err = 0, ev_short = 0, ev_short_en = 0;
    logic ev_resume = 0, ev_consist_fail = 0, ev_sysbus_err = 0, gsusp = 0;
    logic ie_done = 0, ie_err = 0, ie_resume = 0;
    logic run_out, halted_out, irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    uhc_status_ctl u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_td_done(ev_td_done), .ev_td_ioc(ev_td_ioc), .ev_td_err(ev_td_err),
        .ev_short(ev_short), .ev_short_en(ev_short_en), .ev_resume(ev_resume),
        .ev_consist_fail(ev_consist_fail), .ev_sysbus_err(ev_sysbus_err),
        .gsusp(gsusp), .ie_done(ie_done), .ie_err(ie_err), .ie_resume(ie_resume),
        .run_out(run_out), .halted_out(halted_out), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%04h expected=0x%04h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        tick();
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic sts_is(input string req, input string what, input logic [15:0] exp);
        logic [15:0] d;
        rd(A_STS, d);
        chk(req, what, d, exp);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        sts_is("R1", "status after reset", 16'h0020);
        rd(A_CMD, d);
        chk("R1", "command after reset", d, 16'h0000);
        chk("R1", "irq after reset", {15'd0, irq}, 16'h0000);
        chk("R1", "run after reset", {15'd0, run_out}, 16'h0000);
    endtask

    task automatic t_start();
        wr(A_CMD, 16'h0001);
        chk("R9", "run after start", {15'd0, run_out}, 16'h0001);
        tick();
        sts_is("R9", "halted kept after run set", 16'h0020);
        wr(A_STS, 16'h0020);
        sts_is("R3", "halted cleared by write-1", 16'h0000);
    endtask

    task automatic t_completion();
        ev_td_done = 1; ev_td_ioc = 1; tick(); ev_td_done = 0; ev_td_ioc = 0;
        sts_is("R4", "done with ioc", 16'h0001);
        chk("R11", "irq masked", {15'd0, irq}, 16'h0000);
        ie_done = 1; #0.5;
        chk("R11", "irq enabled", {15'd0, irq}, 16'h0001);
        wr(A_STS, 16'h0000);
        sts_is("R3", "write 0 keeps bit", 16'h0001);
        wr(A_STS, 16'h0001);
        sts_is("R3", "write 1 clears bit", 16'h0000);
        chk("R11", "irq drops", {15'd0, irq}, 16'h0000);
        ie_done = 0;
        ev_td_done = 1; tick(); ev_td_done = 0;
        sts_is("R4", "done without ioc", 16'h0000);
        ev_short = 1; tick(); ev_short = 0;
        sts_is("R4", "short without detect", 16'h0000);
        ev_short = 1; ev_short_en = 1; tick(); ev_short = 0; ev_short_en = 0;
        sts_is("R4", "short with detect", 16'h0001);
        wr(A_STS, 16'h0001);
    endtask

    task automatic t_error();
        ev_td_err = 1; ev_td_ioc = 1; tick(); ev_td_err = 0; ev_td_ioc = 0;
        sts_is("R5", "error with ioc", 16'h0003);
        wr(A_STS, 16'h0003);
        ev_td_err = 1; tick(); ev_td_err = 0;
        sts_is("R5", "error alone", 16'h0002);
        ie_err = 1; #0.5;
        chk("R11", "error irq", {15'd0, irq}, 16'h0001);
        ie_err = 0;
        wr(A_STS, 16'h0002);
    endtask

    task automatic t_resume();
        ev_resume = 1; tick(); ev_resume = 0;
        sts_is("R6", "resume not suspended", 16'h0000);
        gsusp = 1; ev_resume = 1; tick(); ev_resume = 0; gsusp = 0;
        sts_is("R6", "resume while suspended", 16'h0004);
        ie_resume = 1; #0.5;
        chk("R11", "resume irq", {15'd0, irq}, 16'h0001);
        ie_resume = 0;
        wr(A_STS, 16'h0004);
    endtask

    task automatic t_reserved();
        logic [15:0] d;
        ev_td_err = 1; tick(); ev_td_err = 0;
        wr(A_STS, 16'hFFC0);
        sts_is("R2", "reserved write ignored", 16'h0002);
        wr(A_STS, 16'h0002);
        wr(A_CMD, 16'hFFFF);
        rd(A_CMD, d);
        chk("R2", "command reserved bits", d, 16'h0001);
    endtask

    task automatic t_consist();
        logic [15:0] d;
        ev_consist_fail = 1; tick(); ev_consist_fail = 0;
        sts_is("R7", "process error, no halt yet", 16'h0010);
        chk("R7", "run dropped", {15'd0, run_out}, 16'h0000);
        rd(A_CMD, d);
        chk("R7", "command reads stopped", d, 16'h0000);
        chk("R11", "fatal irq unmasked", {15'd0, irq}, 16'h0001);
        tick();
        sts_is("R9", "halt one cycle later", 16'h0030);
        wr(A_STS, 16'h0030);
        sts_is("R3", "fatal cleared", 16'h0000);
        chk("R11", "irq released", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_sysbus();
        wr(A_CMD, 16'h0001);
        ev_sysbus_err = 1; tick(); ev_sysbus_err = 0;
        sts_is("R8", "system error, no halt yet", 16'h0008);
        chk("R8", "run dropped", {15'd0, run_out}, 16'h0000);
        chk("R11", "sys irq", {15'd0, irq}, 16'h0001);
        tick();
        sts_is("R9", "halt after sys error", 16'h0028);
        wr(A_STS, 16'h0028);
    endtask

    task automatic t_sw_stop();
        wr(A_CMD, 16'h0001);
        tick();
        wr(A_CMD, 16'h0000);
        sts_is("R9", "no halt on stop edge", 16'h0000);
        tick();
        sts_is("R9", "halt after software stop", 16'h0020);
        wr(A_CMD, 16'h0001);
        tick();
        sts_is("R9", "restart keeps halt", 16'h0020);
        wr(A_STS, 16'h0020);
    endtask

    task automatic t_set_wins();
        ev_td_err = 1; tick(); ev_td_err = 0;
        reg_addr = A_STS; reg_wdata = 16'h0002; reg_wr = 1; ev_td_err = 1;
        tick();
        reg_wr = 0; ev_td_err = 0; reg_wdata = '0;
        sts_is("R10", "set beats clear", 16'h0002);
        wr(A_STS, 16'h0002);
        sts_is("R10", "later clear works", 16'h0000);
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        t_reset();
        t_start();
        t_completion();
        t_error();
        t_resume();
        t_reserved();
        t_consist();
        t_sysbus();
        t_sw_stop();
        t_set_wins();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule